// File: doc/BRIEF.md
# Dual-Bank Configurable Interrupt Controller

This block gathers 32 interrupt request lines into two interrupt outputs: a normal output and a fast output. Each output has its own register bank, and the two banks are copies of each other. Within a bank, every line has its own settings. A line can be level triggered or edge triggered, and it can be active high (rising edge) or active low (falling edge). Bit n of every register refers to line n.

The request lines can come from other clock domains, so they pass through a synchroniser first. After that, each line's state is inverted where its polarity bit asks for it. An edge-mode line latches a pending bit on the active edge, and that bit stays set until software writes a one to it in the clear register. A level-mode line shows its adjusted input directly. The pending vector is ANDed with the enable mask to form the status register, and the OR of the status bits drives the bank's output.

Software reaches the registers through a simple request port. A write completes in one cycle. Read data and a valid strobe appear one cycle after a read request. The reset input is expected to arrive already synchronised to the clock.

Top module: `irq_dualbank_ctrl`

## Requirements
- R1: After reset, the mask, mode, polarity and pending state of both banks are zero, both outputs are low, and every register reads zero.
- R2: The mask register of each bank (normal at byte address 0x04, fast at 0x24) reads back exactly the value last written. A write to one bank does not change the other bank.
- R3: A level line (mode bit 0) with polarity bit 0 shows in status (0x14) and drives the bank output once two clock edges have passed after the input rises. It drops two edges after the input falls.
- R4: When its polarity bit is 1 (polarity at 0x10), a level line is active while its input is low. The source register (0x00) returns each line's synchronised state after the polarity inversion.
- R5: An edge line (mode bit 1 at 0x0C) with polarity 0 latches pending on a rising input edge, three clock edges after the rise. The pending bit stays set after the input falls, until a 1 is written to that bit of the clear register (0x08). Bits written as 0 to the clear register have no effect.
- R6: An edge line with polarity 1 latches pending on a falling input edge.
- R7: When a new edge and a clear of the same line fall in the same cycle, the line stays pending.
- R8: A clear write leaves no lasting effect on a level line that is still active.
- R9: A line whose mask bit is 0 sets no status bit and does not drive the output. An edge latched while the line is masked shows in status once the mask bit is set to 1.
- R10: The fast bank's registers sit at the same layout plus 0x20 (source 0x20, mask 0x24, clear 0x28, mode 0x2C, polarity 0x30, status 0x34). The fast bank drives only the fast output.
- R11: The following read as zero: byte addresses 0x18 to 0x1F, 0x38 to 0x3F and 0x40 or above, addresses that are not word aligned, and the clear registers. Writes to the source and status registers are ignored.
- R12: Read data is valid, with the read-valid strobe high, exactly one cycle after the read request. The strobe is low in every other cycle.
- R13: A bank output stays high while any status bit in that bank is set, and goes low only when all of them have cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with clk |
| irq_in | input | 32 | Interrupt request lines, may be asynchronous |
| bus_en | input | 1 | Register access request |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | 1 | Normal bank interrupt output |
| fiq_out | output | 1 | Fast bank interrupt output |

## Verification
A pending bit that sticks, or that fails to latch, shows on the bank output three edges after the input edge. The status register read in the next cycle shows the same fault. A wrong polarity or synchroniser depth moves the moment the output changes, so the bench samples the output once at each edge after a stimulus. A decode error that touches the wrong bank or register shows up when the registers are read back directly after the write, and when the other bank's output stays quiet.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LINES = 32;
  localparam int BANKS = 2;
  localparam int IDX_W = 3;

  // word index inside one bank, decoded from address bits [4:2]
  typedef enum logic [IDX_W-1:0] {
    IDX_SRC  = 3'd0,
    IDX_MASK = 3'd1,
    IDX_CLR  = 3'd2,
    IDX_MODE = 3'd3,
    IDX_POL  = 3'd4,
    IDX_STAT = 3'd5
  } reg_idx_e;

  typedef struct packed {
    logic [LINES-1:0] src;
    logic [LINES-1:0] mask;
    logic [LINES-1:0] mode;
    logic [LINES-1:0] pol;
    logic [LINES-1:0] pend;
    logic [LINES-1:0] status;
  } bank_view_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= '0;
        end else if (s == 0) begin
          stage_q[s] <= d_i;
        end else begin
          stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_bank.sv
module irq_bank
  import irq_ctrl_pkg::*;
#(
  parameter int N = LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     line_sync,
  input  logic             wr_stb,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [N-1:0]     wr_data,
  output bank_view_t       view_o,
  output logic             out_o
);
  logic [N-1:0] mask_q, mode_q, pol_q, pend_q, prev_q;
  logic [N-1:0] mask_d, mode_d, pol_d, pend_d;
  logic         mask_en, mode_en, pol_en;
  logic [N-1:0] adj, rise, clr_vec, status;

  // next state
  always_comb begin
    mask_en = wr_stb && (wr_idx == IDX_MASK);
    mode_en = wr_stb && (wr_idx == IDX_MODE);
    pol_en  = wr_stb && (wr_idx == IDX_POL);
    clr_vec = (wr_stb && (wr_idx == IDX_CLR)) ? wr_data : '0;
    mask_d  = wr_data;
    mode_d  = wr_data;
    pol_d   = wr_data;
    adj     = line_sync ^ pol_q;
    rise    = adj & ~prev_q;
    // a fresh edge overrides a clear in the same cycle
    pend_d  = mode_q & (rise | (pend_q & ~clr_vec));
    status  = mask_q & ((mode_q & pend_q) | (~mode_q & adj));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      if (mask_en) mask_q <= mask_d;
      if (mode_en) mode_q <= mode_d;
      if (pol_en)  pol_q  <= pol_d;
      pend_q <= pend_d;
      prev_q <= adj;
    end
  end

  assign view_o.src    = adj;
  assign view_o.mask   = mask_q;
  assign view_o.mode   = mode_q;
  assign view_o.pol    = pol_q;
  assign view_o.pend   = pend_q;
  assign view_o.status = status;
  assign out_o         = |status;
endmodule

// File: rtl/irq_dualbank_ctrl.sv
module irq_dualbank_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_in,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_out,
  output logic              fiq_out
);
  localparam int BANK_BIT = 5;
  localparam int TOP_LSB  = BANK_BIT + 1;

  logic [LINES-1:0] line_sync;
  bank_view_t       view [BANKS];
  logic [BANKS-1:0] bank_out;
  logic             in_range, rd_req;
  logic [IDX_W-1:0] idx;
  logic             bank_sel;
  logic [LINES-1:0] rdata_d, rdata_q;
  logic             rvalid_q;

  irq_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (irq_in),
    .q_o   (line_sync)
  );

  always_comb begin
    in_range = (bus_addr[ADDR_W-1:TOP_LSB] == '0) && (bus_addr[1:0] == 2'b00);
    idx      = bus_addr[4:2];
    bank_sel = bus_addr[BANK_BIT];
    rd_req   = bus_en && !bus_wr;
  end

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic wr_stb;
      assign wr_stb = bus_en && bus_wr && in_range && (bank_sel == b[0]);
      irq_bank #(.N(LINES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_sync (line_sync),
        .wr_stb    (wr_stb),
        .wr_idx    (idx),
        .wr_data   (bus_wdata),
        .view_o    (view[b]),
        .out_o     (bank_out[b])
      );
    end
  endgenerate

  // read mux
  always_comb begin
    rdata_d = '0;
    if (in_range) begin
      case (idx)
        IDX_SRC:  rdata_d = view[bank_sel].src;
        IDX_MASK: rdata_d = view[bank_sel].mask;
        IDX_MODE: rdata_d = view[bank_sel].mode;
        IDX_POL:  rdata_d = view[bank_sel].pol;
        IDX_STAT: rdata_d = view[bank_sel].status;
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign irq_out    = bank_out[0];
  assign fiq_out    = bank_out[1];
endmodule

// File: rtl/irq_dualbank_chk.sv
module irq_dualbank_chk
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LINES-1:0]  bus_wdata,
  input logic [LINES-1:0]  bus_rdata,
  input logic              bus_rvalid,
  input logic              irq_out,
  input logic              fiq_out,
  input logic [LINES-1:0]  pend0,
  input logic [LINES-1:0]  mode0
);
  logic [LINES-1:0] shadow_mask [BANKS];
  logic [LINES-1:0] clr0;

  always_comb begin
    clr0 = (bus_en && bus_wr && bus_addr == ADDR_W'(8'h08)) ? bus_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_mask[0] <= '0;
      shadow_mask[1] <= '0;
    end else if (bus_en && bus_wr) begin
      if (bus_addr == ADDR_W'(8'h04)) shadow_mask[0] <= bus_wdata;
      if (bus_addr == ADDR_W'(8'h24)) shadow_mask[1] <= bus_wdata;
    end
  end

  p_rvalid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr) |=> bus_rvalid);

  p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_wr) |=> !bus_rvalid);

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_wr && bus_addr[ADDR_W-1:6] != '0) |=> (bus_rdata == '0));

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mask[0] == '0) |-> !irq_out);

  p_fast_masked_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_mask[1] == '0) |-> !fiq_out);

  p_pending_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend0) & ~$past(clr0) & $past(mode0) & mode0) & ~pend0) == '0));
endmodule

bind irq_dualbank_ctrl irq_dualbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_en     (bus_en),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out),
  .pend0      (view[0].pend),
  .mode0      (view[0].mode)
);

// File: tb/irq_dualbank_ctrl_test.sv
`timescale 1ns/1ps
module irq_dualbank_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        bus_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        irq_out, fiq_out;

  int checks = 0;
  int errors = 0;

  irq_dualbank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle_cfg();
    irq_in = '0;
    wr(8'h04, 0); wr(8'h0C, 0); wr(8'h10, 0);
    wr(8'h24, 0); wr(8'h2C, 0); wr(8'h30, 0);
    cyc(4);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq_out", irq_out, 0);
    chk("R1 fiq_out", fiq_out, 0);
    rd(8'h04, v); chk("R1 mask", v, 0);
    rd(8'h0C, v); chk("R1 mode", v, 0);
    rd(8'h30, v); chk("R1 fast pol", v, 0);
    rd(8'h14, v); chk("R1 status", v, 0);
  endtask

  task automatic t_mask_rb();
    logic [31:0] v;
    wr(8'h04, 32'hA5A5_5A5A);
    rd(8'h04, v); chk("R2 mask readback", v, 32'hA5A5_5A5A);
    rd(8'h24, v); chk("R2 fast mask untouched", v, 0);
    wr(8'h24, 32'h0000_F00F);
    rd(8'h24, v); chk("R2 fast mask readback", v, 32'h0000_F00F);
    rd(8'h04, v); chk("R2 normal mask kept", v, 32'hA5A5_5A5A);
    idle_cfg();
  endtask

  task automatic t_latency();
    bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 8'h04;
    @(negedge clk);
    chk("R12 rvalid high", bus_rvalid, 1);
    bus_en = 1'b0;
    @(negedge clk);
    chk("R12 rvalid low", bus_rvalid, 0);
  endtask

  task automatic t_level_high();
    logic [31:0] v;
    wr(8'h04, 32'h8);
    irq_in[3] = 1'b1;
    @(negedge clk); chk("R3 not yet after one edge", irq_out, 0);
    @(negedge clk); chk("R3 asserted after two edges", irq_out, 1);
    rd(8'h14, v); chk("R3 status", v, 32'h8);
    irq_in[3] = 1'b0;
    @(negedge clk); chk("R3 held one edge", irq_out, 1);
    @(negedge clk); chk("R3 released", irq_out, 0);
    idle_cfg();
  endtask

  task automatic t_level_low();
    logic [31:0] v;
    wr(8'h10, 32'h10);
    wr(8'h04, 32'h10);
    cyc(1);
    chk("R4 active low asserted", irq_out, 1);
    rd(8'h00, v); chk("R4 source inverted", v, 32'h10);
    irq_in[4] = 1'b1;
    cyc(2);
    chk("R4 deasserted on high", irq_out, 0);
    rd(8'h00, v); chk("R4 source after rise", v, 0);
    idle_cfg();
  endtask

  task automatic t_edge_rise();
    logic [31:0] v;
    wr(8'h0C, 32'h80); wr(8'h04, 32'h80); wr(8'h08, 32'hFFFF_FFFF);
    irq_in[7] = 1'b1;
    cyc(2); chk("R5 not latched at two edges", irq_out, 0);
    cyc(1); chk("R5 latched at three edges", irq_out, 1);
    irq_in[7] = 1'b0;
    cyc(4); chk("R5 held after input low", irq_out, 1);
    wr(8'h08, 32'hFFFF_FF7F);
    chk("R5 zero bits ignored", irq_out, 1);
    wr(8'h08, 32'h80);
    chk("R5 cleared", irq_out, 0);
    rd(8'h14, v); chk("R5 status after clear", v, 0);
    idle_cfg();
  endtask

  task automatic t_edge_fall();
    irq_in[9] = 1'b1;
    wr(8'h10, 32'h200); wr(8'h0C, 32'h200); wr(8'h04, 32'h200);
    cyc(4);
    wr(8'h08, 32'h200);
    cyc(3); chk("R6 no pend while high", irq_out, 0);
    irq_in[9] = 1'b0;
    cyc(3); chk("R6 falling edge latched", irq_out, 1);
    wr(8'h08, 32'h200);
    chk("R6 cleared", irq_out, 0);
    idle_cfg();
  endtask

  task automatic t_edge_clear_race();
    wr(8'h0C, 32'h80); wr(8'h04, 32'h80); wr(8'h08, 32'hFFFF_FFFF);
    irq_in[7] = 1'b1;
    cyc(2);
    wr(8'h08, 32'h80);   // sampled on the same edge as the latch
    chk("R7 edge beats clear", irq_out, 1);
    wr(8'h08, 32'h80);
    chk("R7 later clear works", irq_out, 0);
    idle_cfg();
  endtask

  task automatic t_level_clear();
    logic [31:0] v;
    wr(8'h04, 32'h8);
    irq_in[3] = 1'b1;
    cyc(3);
    wr(8'h08, 32'h8);
    chk("R8 level survives clear", irq_out, 1);
    rd(8'h14, v); chk("R8 status kept", v, 32'h8);
    idle_cfg();
  endtask

  task automatic t_masked();
    logic [31:0] v;
    wr(8'h0C, 32'h80); wr(8'h08, 32'hFFFF_FFFF);
    irq_in[7] = 1'b1;
    cyc(4);
    chk("R9 masked output low", irq_out, 0);
    rd(8'h14, v); chk("R9 masked status", v, 0);
    wr(8'h04, 32'h80);
    chk("R9 shows after unmask", irq_out, 1);
    idle_cfg();
    wr(8'h08, 32'hFFFF_FFFF);
  endtask

  task automatic t_fast();
    logic [31:0] v;
    wr(8'h24, 32'h1000);
    irq_in[12] = 1'b1;
    cyc(2);
    chk("R10 fast output", fiq_out, 1);
    chk("R10 normal output quiet", irq_out, 0);
    rd(8'h34, v); chk("R10 fast status", v, 32'h1000);
    rd(8'h14, v); chk("R10 normal status", v, 0);
    rd(8'h20, v); chk("R10 fast source", v, 32'h1000);
    idle_cfg();
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h04, 32'h8);
    irq_in[3] = 1'b1;
    cyc(3);
    rd(8'h40, v); chk("R11 above range", v, 0);
    rd(8'h18, v); chk("R11 gap offset", v, 0);
    rd(8'h08, v); chk("R11 clear reads zero", v, 0);
    rd(8'h05, v); chk("R11 misaligned", v, 0);
    wr(8'h14, 32'h0); wr(8'h00, 32'h0);
    rd(8'h04, v); chk("R11 mask unaffected", v, 32'h8);
    rd(8'h14, v); chk("R11 status unaffected", v, 32'h8);
    idle_cfg();
  endtask

  task automatic t_or();
    wr(8'h0C, 32'h3); wr(8'h04, 32'h3); wr(8'h08, 32'hFFFF_FFFF);
    irq_in[1:0] = 2'b11;
    cyc(3);
    wr(8'h08, 32'h1);
    chk("R13 still high with one left", irq_out, 1);
    wr(8'h08, 32'h2);
    chk("R13 low when all cleared", irq_out, 0);
    idle_cfg();
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_latency();
        t_mask_rb();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_edge_clear_race();
        t_level_clear();
        t_masked();
        t_fast();
        t_unmapped();
        t_or();
      end
      begin
        cyc(20000);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule